// File: doc/BRIEF.md
# Broadcast and multicast storm limiter

This block guards a switch's ingress against floods of broadcast and multicast traffic. For every frame start it receives the destination MAC address and the ingress port. It sorts the frame into broadcast, multicast or unicast. For the two flooding classes it keeps a per-port count of the frames accepted in the current interval. One cycle later it returns a forward or drop verdict.

A single prescaler, clocked by the core clock and shared by all ports, cuts time into fixed intervals. At each interval boundary every count returns to zero. Each port carries an 8-bit frame budget for broadcast and a separate one for multicast. The accepted rate per class is therefore core clock / prescale × budget. A budget of zero exempts that class on that port from limiting. A global enable switches the whole function off.

Top module: `storm_limiter`

## Requirements
- R1: A destination of all 48 ones is broadcast. Any other destination with `frm_dmac[40]` set is multicast; bit 40 is the least significant bit of the first octet, which is `frm_dmac[47:40]`. All other frames are unicast. Unicast frames are always forwarded and never counted.
- R2: `dec_valid` is high in the cycle after each cycle with `frm_valid` high, and low otherwise. In that cycle, `dec_drop` = 1 means drop and 0 means forward. `dec_drop` is never high without `dec_valid`.
- R3: With a nonzero budget L for a class on a port, the first L frames of that class on that port within an interval are forwarded. Later frames of that class on that port in the same interval are dropped. A dropped frame is not counted.
- R4: A budget of 0 means that class on that port is never dropped.
- R5: Broadcast and multicast are counted separately. Each port is counted separately.
- R6: Let P be `cfg_prescale`, with 0 treated as 1. While enabled, the n-th enabled cycle is a boundary cycle when n is a multiple of P, counting from n = 1 at the first enabled cycle after reset or re-enable. Every port's counters return to zero at each boundary. A frame in the cycle just before a boundary still sees the old counts.
- R7: A frame that arrives in a boundary cycle is judged and counted as the first frame of the new interval.
- R8: While `cfg_enable` is low, every frame is forwarded. While it is low, the counters and the prescaler are held at zero.
- R9: During reset, `dec_valid` and `dec_drop` are 0.
- R10: Counts saturate at 255. Suppose 300 broadcast frames arrive on a port with budget 0 within one interval, and the budget is then raised to 255. The next broadcast frame in that interval is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global limiting enable |
| cfg_prescale | input | PRE_W | Interval length in core clock cycles |
| cfg_bc_limit | input | NPORTS*LIM_W | Broadcast budget per port, port p at bits [p*LIM_W +: LIM_W] |
| cfg_mc_limit | input | NPORTS*LIM_W | Multicast budget per port, same layout |
| frm_valid | input | 1 | Frame-start strobe |
| frm_dmac | input | 48 | Destination MAC address, first octet in bits [47:40] |
| frm_port | input | PORT_W | Ingress port number |
| dec_valid | output | 1 | Verdict valid, one cycle after the strobe |
| dec_drop | output | 1 | 1 = drop, 0 = forward |

## Verification
The interval boundary, which clears every counter, can fall in the same cycle as a frame that must read and bump one of those counters. The bench fills port 0's broadcast budget and then steps idle cycles until its own interval model reaches the last cycle before a boundary. It sends one broadcast frame there, which must be dropped against the old count. It sends another in the boundary cycle itself, which must be forwarded. Two more frames must then be forwarded and a third dropped, which confirms that the boundary frame was counted as the first of the new interval.

// File: rtl/storm_limiter.sv
module storm_limiter #(
  parameter int NPORTS = 4,
  parameter int PRE_W  = 16,
  parameter int LIM_W  = 8,
  parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_enable,
  input  logic [PRE_W-1:0]          cfg_prescale,
  input  logic [NPORTS*LIM_W-1:0]   cfg_bc_limit,
  input  logic [NPORTS*LIM_W-1:0]   cfg_mc_limit,
  input  logic                      frm_valid,
  input  logic [47:0]               frm_dmac,
  input  logic [PORT_W-1:0]         frm_port,
  output logic                      dec_valid,
  output logic                      dec_drop
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W:0]   pre_eff, pnext;
  logic             tick;

  assign pnext   = {1'b0, pcnt} + 1'b1;
  assign pre_eff = (cfg_prescale == '0) ? (PRE_W+1)'(1) : {1'b0, cfg_prescale};
  assign tick    = cfg_enable && (pnext >= pre_eff);

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_enable) pcnt <= '0;
    else if (tick)             pcnt <= '0;
    else                       pcnt <= pnext[PRE_W-1:0];
  end

  logic is_bc, is_mc, port_ok;
  assign is_bc   = &frm_dmac;
  assign is_mc   = frm_dmac[40] && !is_bc;
  assign port_ok = 32'(frm_port) < NPORTS;

  logic [LIM_W-1:0] bc_all [NPORTS];
  logic [LIM_W-1:0] mc_all [NPORTS];
  logic [LIM_W-1:0] lim, cur_cnt, cnt_eff, cnt_inc;
  logic             hit;

  assign lim     = is_bc ? cfg_bc_limit[frm_port*LIM_W +: LIM_W]
                         : cfg_mc_limit[frm_port*LIM_W +: LIM_W];
  assign cur_cnt = is_bc ? bc_all[frm_port] : mc_all[frm_port];
  assign cnt_eff = tick ? '0 : cur_cnt;
  assign cnt_inc = (&cnt_eff) ? cnt_eff : cnt_eff + 1'b1;
  assign hit     = frm_valid && cfg_enable && port_ok && (is_bc || is_mc) &&
                   (lim != '0) && (cnt_eff >= lim);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [LIM_W-1:0] bc_q, mc_q;
    logic             take;

    assign take = frm_valid && cfg_enable && port_ok &&
                  (32'(frm_port) == p) && !hit;

    always_ff @(posedge clk) begin
      if (!rst_n || !cfg_enable) begin
        bc_q <= '0;
        mc_q <= '0;
      end else begin
        if (take && is_bc) bc_q <= cnt_inc;
        else if (tick)     bc_q <= '0;
        if (take && is_mc) mc_q <= cnt_inc;
        else if (tick)     mc_q <= '0;
      end
    end

    assign bc_all[p] = bc_q;
    assign mc_all[p] = mc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_drop  <= 1'b0;
    end else begin
      dec_valid <= frm_valid;
      dec_drop  <= hit;
    end
  end

endmodule

module storm_limiter_chk #(
  parameter int NPORTS = 4,
  parameter int PRE_W  = 16,
  parameter int LIM_W  = 8,
  parameter int PORT_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_enable,
  input logic [NPORTS*LIM_W-1:0] cfg_bc_limit,
  input logic [NPORTS*LIM_W-1:0] cfg_mc_limit,
  input logic                    frm_valid,
  input logic [47:0]             frm_dmac,
  input logic [PORT_W-1:0]       frm_port,
  input logic                    dec_valid,
  input logic                    dec_drop
);
  logic [LIM_W-1:0] bc_sel, mc_sel;
  assign bc_sel = cfg_bc_limit[frm_port*LIM_W +: LIM_W];
  assign mc_sel = cfg_mc_limit[frm_port*LIM_W +: LIM_W];

  assert_decision_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> dec_valid);
  assert_idle_no_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !dec_valid);
  assert_drop_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_drop |-> dec_valid);
  assert_unicast_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_dmac[40]) |=> !dec_drop);
  assert_zero_limit_bc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (&frm_dmac) && bc_sel == '0) |=> !dec_drop);
  assert_zero_limit_mc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_dmac[40] && !(&frm_dmac) && mc_sel == '0) |=> !dec_drop);
  assert_disabled_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !dec_drop);
endmodule

bind storm_limiter storm_limiter_chk #(
  .NPORTS(NPORTS), .PRE_W(PRE_W), .LIM_W(LIM_W), .PORT_W(PORT_W)
) u_chk (.*);

// File: tb/sim_storm_limiter.sv
`timescale 1ns/1ps
module sim_storm_limiter;
  localparam int NP = 4;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] MC2 = 48'h33FF_FFFF_FFFF;
  localparam logic [47:0] UC2 = 48'hFEFF_FFFF_FFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cfg_enable, frm_valid, dec_valid, dec_drop;
  logic [15:0]   cfg_prescale;
  logic [NP*8-1:0] cfg_bc_limit, cfg_mc_limit;
  logic [47:0]   frm_dmac;
  logic [1:0]    frm_port;

  storm_limiter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_prescale(cfg_prescale),
    .cfg_bc_limit(cfg_bc_limit), .cfg_mc_limit(cfg_mc_limit),
    .frm_valid(frm_valid), .frm_dmac(frm_dmac), .frm_port(frm_port),
    .dec_valid(dec_valid), .dec_drop(dec_drop)
  );

  int n_tests = 0, n_fail = 0;
  bit qv[$], qd[$];
  string qt[$];

  bit en;
  int pre, mp;
  int bcl[NP], mcl[NP], mbc[NP], mmc[NP];

  always_comb begin
    cfg_enable   = en;
    cfg_prescale = 16'(pre);
    for (int i = 0; i < NP; i++) begin
      cfg_bc_limit[i*8 +: 8] = 8'(bcl[i]);
      cfg_mc_limit[i*8 +: 8] = 8'(mcl[i]);
    end
  end

  task automatic drive(input bit v, input logic [47:0] mac, input int port, input string tag);
    int p_len, cls, c, l, nc;
    bit tk, drop;
    frm_valid = v; frm_dmac = mac; frm_port = 2'(port);
    p_len = (pre == 0) ? 1 : pre;
    drop = 1'b0; c = 0; l = 0; nc = 0;
    if (!en) begin
      mp = 0;
      for (int i = 0; i < NP; i++) begin mbc[i] = 0; mmc[i] = 0; end
    end else begin
      tk  = (mp + 1 >= p_len);
      cls = (&mac) ? 1 : (mac[40] ? 2 : 0);
      if (v && cls != 0) begin
        c    = tk ? 0 : ((cls == 1) ? mbc[port] : mmc[port]);
        l    = (cls == 1) ? bcl[port] : mcl[port];
        drop = (l != 0) && (c >= l);
        nc   = drop ? c : ((c >= 255) ? 255 : c + 1);
      end
      if (tk) for (int i = 0; i < NP; i++) begin mbc[i] = 0; mmc[i] = 0; end
      if (v && cls == 1) mbc[port] = nc;
      if (v && cls == 2) mmc[port] = nc;
      mp = tk ? 0 : mp + 1;
    end
    qv.push_back(v); qd.push_back(drop); qt.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    bit ev, ed;
    string t;
    forever begin
      @(posedge clk); #1;
      if (qv.size() > 0) begin
        ev = qv.pop_front(); ed = qd.pop_front(); t = qt.pop_front();
        n_tests++;
        if (dec_valid !== ev || (ev && dec_drop !== ed)) begin
          n_fail++;
          $display("FAIL %s: valid/drop = %b/%b, expected %b/%b", t, dec_valid, dec_drop, ev, ed);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    en = 0; pre = 40; mp = 0;
    bcl = '{3, 0, 1, 0}; mcl = '{2, 1, 0, 0};
    for (int i = 0; i < NP; i++) begin mbc[i] = 0; mmc[i] = 0; end
    rst_n = 0; frm_valid = 0; frm_dmac = '0; frm_port = '0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (dec_valid !== 1'b0 || dec_drop !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: valid/drop = %b/%b, expected 0/0", dec_valid, dec_drop);
    end
    rst_n = 1; en = 1;

    for (int i = 0; i < 5; i++) drive(1, BC, 0, "R3");
    for (int i = 0; i < 4; i++) drive(1, MC, 0, "R5");
    for (int i = 0; i < 3; i++) drive(1, UC2, 0, "R1");
    drive(1, MC2, 1, "R1");
    drive(1, MC2, 1, "R1");
    for (int i = 0; i < 5; i++) drive(1, BC, 1, "R4");
    drive(0, '0, 0, "R2");
    drive(0, '0, 0, "R2");

    while (mp != pre - 2) drive(0, '0, 0, "R2");
    drive(1, BC, 0, "R6");
    drive(1, BC, 0, "R7");
    for (int i = 0; i < 3; i++) drive(1, BC, 0, "R7");

    pre = 0;
    for (int i = 0; i < 6; i++) drive(1, BC, 2, "R6");

    pre = 40; en = 0;
    for (int i = 0; i < 5; i++) drive(1, BC, 0, "R8");
    en = 1;
    for (int i = 0; i < 4; i++) drive(1, BC, 0, "R8");

    pre = 1000;
    for (int i = 0; i < 300; i++) drive(1, BC, 3, "R10");
    bcl[3] = 255;
    drive(1, BC, 3, "R10");
    for (int i = 0; i < 3; i++) drive(0, '0, 0, "R2");

    @(posedge clk); #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule